// File: doc/BRIEF.md
# MII Management Register Slave

This block is the management side of a 10/100 Ethernet PHY. It runs on the management clock and watches the serial management data line. It decodes read and write frames aimed at it and serves a bank of 32 registers, each 16 bits wide. For reads it returns the register contents on the same line during the data phase. The line is split into an input, an output and an output enable, and the pad logic above the block combines them.

On a synchronous reset the block latches its own 5-bit station address from strap pins. It answers both that address and the broadcast address 0. Reserved locations and identity registers do not take writes. The control register at location 0 drives the PHY's mode pins: loopback, speed, negotiation enable, isolate and duplex. It also carries two self-clearing commands, a soft reset and a negotiation restart, which appear as one-cycle pulses.

Top module: `mii_mgmt_slave`

## Requirements
- R1: During reset the block latches `strap_addr_i`. Register 25 then reads with that address in bits 4:0 and zeros in bits 15:5, and writes to it change nothing.
- R2: A frame consists of at least 32 ones, the start pattern 0 then 1, an opcode (10 for read, 01 for write), a 5-bit station address, a 5-bit register address, two turnaround bits and 16 data bits. All fields are sent MSB first. A value written to a writable register reads back unchanged.
- R3: Frames carrying station address 0 are accepted for both read and write, whatever address was strapped.
- R4: A frame carrying any other station address leaves `mdio_oe_o` low for the whole frame, and a write in such a frame has no effect.
- R5: Registers 7 to 17, 26 and 29 to 31 read as zero, and writes to them have no effect.
- R6: Registers 1, 2 and 3 read as fixed parameter values, by default 16'h7809, 16'h2000 and 16'h5C01, and writes to them have no effect.
- R7: Writing 1 to bit 9 of register 0 makes `ctl_an_restart_o` high for exactly one clock cycle. The bit then reads as 0.
- R8: Writing 1 to bit 15 of register 0 makes `ctl_soft_reset_o` high for exactly one clock cycle. On the next cycle every register returns to its default: register 0 to 16'h3000, register 4 to 16'h01E1, and all other writable registers to 0.
- R9: The control outputs follow register 0: bit 14 drives loopback, bit 13 drives 100 Mb/s, bit 12 drives negotiation enable, bit 10 drives isolate and bit 8 drives full duplex.
- R10: While the latched address is 0, bit 10 of register 0 and `ctl_isolate_o` read 1, even after a write of 0 to that bit.
- R11: On an addressed read the block releases the line in the first turnaround bit and drives 0 in the second. It then drives the 16 data bits MSB first and releases the line in the cycle after the last data bit.
- R12: A frame preceded by fewer than 32 consecutive ones is ignored.
- R13: After reset `mdio_oe_o` is low, register 0 reads 16'h3000 (the isolate bit stays 0 unless R10 applies) and register 4 reads 16'h01E1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; strap address is captured while high |
| strap_addr_i | input | 5 | Strapped station address |
| mdio_i | input | 1 | Serial management data sampled from the line |
| mdio_o | output | 1 | Serial data driven by the block |
| mdio_oe_o | output | 1 | High while the block drives the line |
| ctl_soft_reset_o | output | 1 | One-cycle pulse for a soft reset command |
| ctl_loopback_o | output | 1 | Loopback mode |
| ctl_speed100_o | output | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| ctl_an_enable_o | output | 1 | Negotiation enable |
| ctl_isolate_o | output | 1 | Isolate the data interface |
| ctl_an_restart_o | output | 1 | One-cycle pulse to restart negotiation |
| ctl_full_duplex_o | output | 1 | Full duplex select |

## Verification
The hardest cases to reach are the self-clearing commands and the forced isolate bit.

- **Self-clearing commands.** Each pulse lasts one cycle and appears two edges after the last data bit. Each write task therefore keeps clocking idle ones and samples the pulse output on each of the following cycles. It then reads the register back in a separate frame, which shows the command bit already cleared and, for soft reset, every register back at its default.
- **Forced isolate.** Reaching it needs a second hard reset with the strap pins at 0. After that reset only the broadcast address can reach the block, so the bench writes isolate to 0 through the broadcast address and confirms the bit still reads 1.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

  localparam int MGMT_DW = 16;
  localparam int MGMT_RAW = 5;
  localparam int MGMT_PAW = 5;
  localparam int MGMT_PRE = 32;

  // Bit positions in the control register
  localparam int CB_SRST = 15;
  localparam int CB_LOOP = 14;
  localparam int CB_SPD = 13;
  localparam int CB_ANEN = 12;
  localparam int CB_ISO = 10;
  localparam int CB_RSTRT = 9;
  localparam int CB_FDX = 8;

  localparam logic [MGMT_DW-1:0] CTRL_DEFAULT = 16'h3000;

  typedef enum logic [2:0] {
    FR_PRE,
    FR_START,
    FR_HDR,
    FR_TA,
    FR_DATA
  } frame_st_t;

  localparam logic [1:0] OPC_WR = 2'b01;
  localparam logic [1:0] OPC_RD = 2'b10;

  function automatic bit reg_reserved(int a);
    return ((a >= 7) && (a <= 17)) || (a == 26) || (a >= 29);
  endfunction

  function automatic bit reg_fixed(int a);
    return (a == 1) || (a == 2) || (a == 3) || (a == 25);
  endfunction

endpackage

// File: rtl/mii_frame_engine.sv
module mii_frame_engine
  import mii_mgmt_pkg::*;
#(
  parameter int DW = MGMT_DW,
  parameter int RAW = MGMT_RAW,
  parameter int PAW = MGMT_PAW,
  parameter int PRE_LEN = MGMT_PRE
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mdio_i,
  input  logic [PAW-1:0] my_addr,
  output logic [RAW-1:0] rd_addr,
  input  logic [DW-1:0]  rd_data,
  output logic           wr_en,
  output logic [RAW-1:0] wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic           mdio_o,
  output logic           mdio_oe_o
);

  localparam int HDR_W = 2 + PAW + RAW;
  localparam int CNT_MAX = (HDR_W > DW) ? HDR_W : DW;
  localparam int CW = $clog2(CNT_MAX);
  localparam int OW = $clog2(PRE_LEN + 1);
  localparam logic [OW-1:0] ONES_FULL = OW'(PRE_LEN);

  frame_st_t st;
  logic [OW-1:0] ones;
  logic [CW-1:0] cnt;
  logic [HDR_W-2:0] hdr;
  logic [HDR_W-1:0] hdr_next;
  logic [DW-2:0] rx;
  logic [DW-1:0] tx;
  logic [RAW-1:0] reg_q;
  logic is_rd, is_wr;

  logic [1:0] opc;
  logic [PAW-1:0] phy;
  logic hit;

  assign hdr_next = {hdr, mdio_i};
  assign opc = hdr_next[HDR_W-1 -: 2];
  assign phy = hdr_next[RAW +: PAW];
  assign rd_addr = hdr_next[RAW-1:0];
  assign hit = (phy == my_addr) || (phy == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= FR_PRE;
      ones <= '0;
      cnt <= '0;
      hdr <= '0;
      rx <= '0;
      tx <= '0;
      reg_q <= '0;
      is_rd <= 1'b0;
      is_wr <= 1'b0;
      wr_en <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      mdio_o <= 1'b0;
      mdio_oe_o <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      case (st)
        FR_PRE: begin
          if (mdio_i) begin
            if (ones != ONES_FULL) ones <= ones + 1'b1;
          end else begin
            if (ones == ONES_FULL) st <= FR_START;
            ones <= '0;
          end
        end
        FR_START: begin
          st <= mdio_i ? FR_HDR : FR_PRE;
          cnt <= '0;
        end
        FR_HDR: begin
          hdr <= hdr_next[HDR_W-2:0];
          cnt <= cnt + 1'b1;
          if (cnt == CW'(HDR_W - 1)) begin
            st <= FR_TA;
            cnt <= '0;
            is_rd <= hit && (opc == OPC_RD);
            is_wr <= hit && (opc == OPC_WR);
            reg_q <= rd_addr;
            tx <= rd_data;
          end
        end
        FR_TA: begin
          cnt <= cnt + 1'b1;
          if (cnt == '0) begin
            mdio_oe_o <= is_rd;
            mdio_o <= 1'b0;
          end else begin
            st <= FR_DATA;
            cnt <= '0;
            mdio_o <= tx[DW-1];
            tx <= {tx[DW-2:0], 1'b0};
          end
        end
        FR_DATA: begin
          rx <= {rx[DW-3:0], mdio_i};
          cnt <= cnt + 1'b1;
          mdio_o <= tx[DW-1];
          tx <= {tx[DW-2:0], 1'b0};
          if (cnt == CW'(DW - 1)) begin
            st <= FR_PRE;
            ones <= '0;
            mdio_oe_o <= 1'b0;
            mdio_o <= 1'b0;
            wr_en <= is_wr;
            wr_addr <= reg_q;
            wr_data <= {rx, mdio_i};
          end
        end
        default: st <= FR_PRE;
      endcase
    end
  end

  // R11: no driving outside the turnaround and data phases
  p_quiet_outside_resp_r11: assert property (@(posedge clk) disable iff (rst)
    (st == FR_PRE || st == FR_START || st == FR_HDR) |-> !mdio_oe_o);

  // R11: the first driven bit is the turnaround zero
  p_ta_zero_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe_o) |-> !mdio_o);

  // R4: only an addressed read may drive the line
  p_no_drive_unaddressed_r4: assert property (@(posedge clk) disable iff (rst)
    mdio_oe_o |-> is_rd);

  // R2: one write strobe per frame
  p_wr_single_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

endmodule

// File: rtl/mii_reg_bank.sv
module mii_reg_bank
  import mii_mgmt_pkg::*;
#(
  parameter int DW = MGMT_DW,
  parameter int RAW = MGMT_RAW,
  parameter int PAW = MGMT_PAW,
  parameter logic [DW-1:0] STATUS_VAL = 16'h7809,
  parameter logic [DW-1:0] ID_HI = 16'h2000,
  parameter logic [DW-1:0] ID_LO = 16'h5C01,
  parameter logic [DW-1:0] ADV_DEFAULT = 16'h01E1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [PAW-1:0] strap_addr,
  output logic [PAW-1:0] my_addr,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [RAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           ctl_soft_reset,
  output logic           ctl_loopback,
  output logic           ctl_speed100,
  output logic           ctl_an_enable,
  output logic           ctl_isolate,
  output logic           ctl_an_restart,
  output logic           ctl_full_duplex
);

  localparam int NREG = 1 << RAW;

  logic [PAW-1:0] addr_q;
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] ctrl_view;
  logic iso_force;
  logic soft_rst;
  logic [DW-1:0] regv [NREG];

  always_ff @(posedge clk) begin
    if (rst) addr_q <= strap_addr;
  end

  assign my_addr = addr_q;
  assign iso_force = (addr_q == '0);
  assign soft_rst = ctrl_q[CB_SRST];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ctrl_q <= CTRL_DEFAULT;
    end else begin
      ctrl_q[CB_RSTRT] <= 1'b0;
      if (wr_en && (wr_addr == '0)) ctrl_q <= wr_data;
    end
  end

  always_comb begin
    ctrl_view = ctrl_q;
    ctrl_view[CB_ISO] = ctrl_q[CB_ISO] | iso_force;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_ctrl
      assign regv[i] = ctrl_view;
    end else if (reg_reserved(i)) begin : g_rsv
      assign regv[i] = '0;
    end else if (reg_fixed(i)) begin : g_fixed
      if (i == 1) begin : g_stat
        assign regv[i] = STATUS_VAL;
      end else if (i == 2) begin : g_idh
        assign regv[i] = ID_HI;
      end else if (i == 3) begin : g_idl
        assign regv[i] = ID_LO;
      end else begin : g_adr
        assign regv[i] = DW'(addr_q);
      end
    end else begin : g_rw
      localparam logic [DW-1:0] DFLT = (i == 4) ? ADV_DEFAULT : '0;
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst || soft_rst) q <= DFLT;
        else if (wr_en && (wr_addr == RAW'(i))) q <= wr_data;
      end
      assign regv[i] = q;
    end
  end

  assign rd_data = regv[rd_addr];

  assign ctl_soft_reset = ctrl_q[CB_SRST];
  assign ctl_loopback = ctrl_q[CB_LOOP];
  assign ctl_speed100 = ctrl_q[CB_SPD];
  assign ctl_an_enable = ctrl_q[CB_ANEN];
  assign ctl_isolate = ctrl_view[CB_ISO];
  assign ctl_an_restart = ctrl_q[CB_RSTRT];
  assign ctl_full_duplex = ctrl_q[CB_FDX];

  // R7: restart command lasts one cycle
  p_restart_clears_r7: assert property (@(posedge clk) disable iff (rst)
    ctl_an_restart |=> !ctl_an_restart);

  // R8: soft reset command lasts one cycle and restores the control default
  p_reset_clears_r8: assert property (@(posedge clk) disable iff (rst)
    ctl_soft_reset |=> (!ctl_soft_reset && ctl_an_enable && ctl_speed100));

  // R10: zero strap keeps isolate set
  p_iso_forced_r10: assert property (@(posedge clk) disable iff (rst)
    (my_addr == '0) |-> ctl_isolate);

  // R1: latched address only changes in reset
  p_addr_held_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(my_addr));

endmodule

// File: rtl/mii_mgmt_slave.sv
module mii_mgmt_slave
  import mii_mgmt_pkg::*;
#(
  parameter int DW = MGMT_DW,
  parameter int RAW = MGMT_RAW,
  parameter int PAW = MGMT_PAW,
  parameter int PRE_LEN = MGMT_PRE
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [PAW-1:0] strap_addr_i,
  input  logic           mdio_i,
  output logic           mdio_o,
  output logic           mdio_oe_o,
  output logic           ctl_soft_reset_o,
  output logic           ctl_loopback_o,
  output logic           ctl_speed100_o,
  output logic           ctl_an_enable_o,
  output logic           ctl_isolate_o,
  output logic           ctl_an_restart_o,
  output logic           ctl_full_duplex_o
);

  logic [PAW-1:0] my_addr;
  logic [RAW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic wr_en;
  logic [RAW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  mii_frame_engine #(
    .DW(DW), .RAW(RAW), .PAW(PAW), .PRE_LEN(PRE_LEN)
  ) frame_i (
    .clk(clk),
    .rst(rst),
    .mdio_i(mdio_i),
    .my_addr(my_addr),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .wr_en(wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o)
  );

  mii_reg_bank #(
    .DW(DW), .RAW(RAW), .PAW(PAW)
  ) bank_i (
    .clk(clk),
    .rst(rst),
    .strap_addr(strap_addr_i),
    .my_addr(my_addr),
    .wr_en(wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .ctl_soft_reset(ctl_soft_reset_o),
    .ctl_loopback(ctl_loopback_o),
    .ctl_speed100(ctl_speed100_o),
    .ctl_an_enable(ctl_an_enable_o),
    .ctl_isolate(ctl_isolate_o),
    .ctl_an_restart(ctl_an_restart_o),
    .ctl_full_duplex(ctl_full_duplex_o)
  );

endmodule

// File: tb/mii_mgmt_slave_tb.sv
`timescale 1ns/1ps
module mii_mgmt_slave_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] strap = 5'd5;
  logic mdio_in = 1'b1;
  logic mdio_out, mdio_oe;
  logic c_srst, c_loop, c_spd, c_anen, c_iso, c_rstrt, c_fdx;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  mii_mgmt_slave dut_i (
    .clk(clk), .rst(rst), .strap_addr_i(strap), .mdio_i(mdio_in),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe),
    .ctl_soft_reset_o(c_srst), .ctl_loopback_o(c_loop),
    .ctl_speed100_o(c_spd), .ctl_an_enable_o(c_anen),
    .ctl_isolate_o(c_iso), .ctl_an_restart_o(c_rstrt),
    .ctl_full_duplex_o(c_fdx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one bit; outputs seen here come from the previous rising edge.
  task automatic bit_out(input logic b);
    @(negedge clk);
    mdio_in = b;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) bit_out(1'b1);
  endtask

  task automatic header(input int pre, input logic [1:0] op, input logic [4:0] phy,
                        input logic [4:0] ra);
    idle(pre);
    bit_out(1'b0); bit_out(1'b1);
    bit_out(op[1]); bit_out(op[0]);
    for (int k = 4; k >= 0; k--) bit_out(phy[k]);
    for (int k = 4; k >= 0; k--) bit_out(ra[k]);
  endtask

  task automatic wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    header(32, 2'b01, phy, ra);
    bit_out(1'b1); bit_out(1'b0);
    for (int k = 15; k >= 0; k--) bit_out(d[k]);
  endtask

  task automatic rd(input int pre, input logic [4:0] phy, input logic [4:0] ra,
                    output logic [15:0] d, output logic ta_ok, output logic drove);
    header(pre, 2'b10, phy, ra);
    drove = 1'b0;
    bit_out(1'b1);
    ta_ok = (mdio_oe === 1'b0);
    drove |= (mdio_oe === 1'b1);
    bit_out(1'b1);
    ta_ok &= (mdio_oe === 1'b1) && (mdio_out === 1'b0);
    drove |= (mdio_oe === 1'b1);
    for (int k = 15; k >= 0; k--) begin
      bit_out(1'b1);
      d[k] = mdio_out;
      ta_ok &= (mdio_oe === 1'b1);
      drove |= (mdio_oe === 1'b1);
    end
    bit_out(1'b1);
    ta_ok &= (mdio_oe === 1'b0);
    drove |= (mdio_oe === 1'b1);
  endtask

  task automatic hard_reset(input logic [4:0] s);
    strap = s;
    rst = 1'b1;
    mdio_in = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state;
    logic [15:0] d; logic ok, dr;
    check("R13 oe after reset", {31'b0, mdio_oe}, 32'd0);
    check("R13 ctl outputs", {25'b0, c_srst, c_loop, c_spd, c_anen, c_iso, c_rstrt, c_fdx},
          32'b0011000);
    rd(32, 5'd5, 5'd0, d, ok, dr);
    check("R13 reg0 default", {16'b0, d}, 32'h3000);
    check("R11 turnaround and release", {31'b0, ok}, 32'd1);
    rd(32, 5'd5, 5'd4, d, ok, dr);
    check("R13 reg4 default", {16'b0, d}, 32'h01E1);
  endtask

  task automatic t_strap_addr;
    logic [15:0] d; logic ok, dr;
    rd(32, 5'd5, 5'd25, d, ok, dr);
    check("R1 reg25 holds strap", {16'b0, d}, 32'h0005);
    wr(5'd5, 5'd25, 16'hFFFF);
    rd(32, 5'd5, 5'd25, d, ok, dr);
    check("R1 reg25 write ignored", {16'b0, d}, 32'h0005);
  endtask

  task automatic t_roundtrip;
    logic [15:0] d; logic ok, dr;
    wr(5'd5, 5'd4, 16'hA5C3);
    rd(32, 5'd5, 5'd4, d, ok, dr);
    check("R2 reg4 round trip", {16'b0, d}, 32'hA5C3);
    check("R11 data phase timing", {31'b0, ok}, 32'd1);
    wr(5'd5, 5'd18, 16'h8001);
    rd(32, 5'd5, 5'd18, d, ok, dr);
    check("R2 reg18 round trip", {16'b0, d}, 32'h8001);
  endtask

  task automatic t_broadcast;
    logic [15:0] d; logic ok, dr;
    wr(5'd0, 5'd21, 16'h3C5A);
    rd(32, 5'd0, 5'd21, d, ok, dr);
    check("R3 broadcast round trip", {16'b0, d}, 32'h3C5A);
    check("R3 broadcast drives", {31'b0, ok}, 32'd1);
  endtask

  task automatic t_foreign;
    logic [15:0] d; logic ok, dr;
    wr(5'd9, 5'd4, 16'hBEEF);
    rd(32, 5'd9, 5'd4, d, ok, dr);
    check("R4 foreign read not driven", {31'b0, dr}, 32'd0);
    rd(32, 5'd5, 5'd4, d, ok, dr);
    check("R4 foreign write ignored", {16'b0, d}, 32'hA5C3);
  endtask

  task automatic t_reserved;
    logic [15:0] d; logic ok, dr;
    wr(5'd5, 5'd10, 16'hFFFF);
    rd(32, 5'd5, 5'd10, d, ok, dr);
    check("R5 reg10 stays zero", {16'b0, d}, 32'h0);
    wr(5'd5, 5'd26, 16'hFFFF);
    rd(32, 5'd5, 5'd26, d, ok, dr);
    check("R5 reg26 stays zero", {16'b0, d}, 32'h0);
    wr(5'd5, 5'd31, 16'hFFFF);
    rd(32, 5'd5, 5'd31, d, ok, dr);
    check("R5 reg31 stays zero", {16'b0, d}, 32'h0);
  endtask

  task automatic t_fixed;
    logic [15:0] d; logic ok, dr;
    wr(5'd5, 5'd2, 16'hFFFF);
    rd(32, 5'd5, 5'd2, d, ok, dr);
    check("R6 reg2 fixed", {16'b0, d}, 32'h2000);
    rd(32, 5'd5, 5'd1, d, ok, dr);
    check("R6 reg1 fixed", {16'b0, d}, 32'h7809);
    rd(32, 5'd5, 5'd3, d, ok, dr);
    check("R6 reg3 fixed", {16'b0, d}, 32'h5C01);
  endtask

  task automatic t_restart;
    logic [15:0] d; logic ok, dr;
    wr(5'd5, 5'd0, 16'h3200);
    idle(1);
    check("R7 no pulse before commit", {31'b0, c_rstrt}, 32'd0);
    idle(1);
    check("R7 restart pulse", {31'b0, c_rstrt}, 32'd1);
    idle(1);
    check("R7 restart clears", {31'b0, c_rstrt}, 32'd0);
    rd(32, 5'd5, 5'd0, d, ok, dr);
    check("R7 restart reads zero", {16'b0, d}, 32'h3000);
  endtask

  task automatic t_ctl_map;
    wr(5'd5, 5'd0, 16'h0100);
    idle(2);
    check("R9 fdx speed10 an off", {28'b0, c_spd, c_anen, c_fdx, c_iso}, 32'b0010);
    wr(5'd5, 5'd0, 16'h4400);
    idle(2);
    check("R9 loop iso", {28'b0, c_loop, c_iso, c_fdx, c_spd}, 32'b1100);
  endtask

  task automatic t_soft_reset;
    logic [15:0] d; logic ok, dr;
    wr(5'd5, 5'd4, 16'h1234);
    wr(5'd5, 5'd0, 16'h8000);
    idle(2);
    check("R8 reset pulse", {31'b0, c_srst}, 32'd1);
    idle(1);
    check("R8 reset clears", {30'b0, c_srst, c_loop}, 32'd0);
    rd(32, 5'd5, 5'd4, d, ok, dr);
    check("R8 reg4 back to default", {16'b0, d}, 32'h01E1);
    rd(32, 5'd5, 5'd0, d, ok, dr);
    check("R8 reg0 back to default", {16'b0, d}, 32'h3000);
    rd(32, 5'd5, 5'd18, d, ok, dr);
    check("R8 reg18 back to zero", {16'b0, d}, 32'h0);
  endtask

  task automatic t_short_pre;
    logic [15:0] d; logic ok, dr;
    rd(20, 5'd5, 5'd4, d, ok, dr);
    check("R12 short preamble ignored", {31'b0, dr}, 32'd0);
    rd(32, 5'd5, 5'd4, d, ok, dr);
    check("R12 full preamble served", {31'b0, ok}, 32'd1);
  endtask

  task automatic t_strap_zero;
    logic [15:0] d; logic ok, dr;
    hard_reset(5'd0);
    @(negedge clk);
    check("R10 isolate at reset", {31'b0, c_iso}, 32'd1);
    wr(5'd0, 5'd0, 16'h3000);
    idle(2);
    check("R10 isolate held", {31'b0, c_iso}, 32'd1);
    rd(32, 5'd0, 5'd0, d, ok, dr);
    check("R10 reg0 shows isolate", {16'b0, d}, 32'h3400);
    rd(32, 5'd0, 5'd25, d, ok, dr);
    check("R1 reg25 zero strap", {16'b0, d}, 32'h0);
  endtask

  initial begin
    hard_reset(5'd5);
    @(negedge clk);
    t_reset_state();
    t_strap_addr();
    t_roundtrip();
    t_broadcast();
    t_foreign();
    t_reserved();
    t_fixed();
    t_restart();
    t_ctl_map();
    t_soft_reset();
    t_short_pre();
    t_strap_zero();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule